// File: doc/BRIEF.md
# SCL Timing Generator

This block paces the clock line of a two-wire serial bus master. It sets the low and high phases of SCL from a handful of small configuration fields. It also marks two moments inside each low phase: the first cycle in which the data line may change, and the cycle in which the clock is let go. Every interval is measured in cycles of the block clock. Each one is a fixed two-cycle offset plus a small sum scaled by a prescale factor of (multiplier + 1).

The high phase does not start counting when the block releases SCL. It starts when the filtered line is actually seen high. A slave that holds the line low therefore lengthens the low phase, and the high phase still keeps its full length. Both raw bus inputs pass through a two-stage synchroniser. They then pass a glitch filter that rejects pulses up to spike × (multiplier + 1) cycles wide. The filtered levels are outputs of the block.

The configuration inputs are registered before use. They must be stable for at least one cycle before `run_i` is raised, and they must stay stable while the generator runs.

Top module: `scl_timing_gen`

## Requirements
- R1: During and after reset `scl_o`, `scl_filt_o` and `sda_filt_o` are 1, and `sda_chg_o` and `scl_rel_o` are 0.
- R2: Let span(x) = 2 + (2 + spike_i + x) × (mult_i + 1). Each low phase lasts max(TL, TH + TS) cycles. Here TL = span(high_i × k), with k = 1 when `ratio2_i` is 0 and k = 2 when it is 1. TH = span(hold_i) and TS = span(setup_i).
- R3: After a release, `scl_o` stays 1 for exactly span(high_i) cycles, counted from the first cycle in which `scl_filt_o` is 1. It then falls if `run_i` is 1.
- R4: While the filtered SCL stays low after a release (a slave stretching the clock), `scl_o` stays 1 and the high phase does not end.
- R5: `sda_chg_o` pulses for one cycle, once per low phase, in the cycle preceded by exactly span(hold_i) low cycles (low-cycle index span(hold_i), counting from 0).
- R6: `scl_rel_o` pulses for one cycle in the last low cycle of each phase, and `scl_o` is 1 in the next cycle.
- R7: A level that a bus input first presents at clock edge k reaches the matching filtered output at edge k + 2 + W, where W = spike_i × (mult_i + 1), provided the level is held for at least W + 1 edges.
- R8: A pulse that is held for at most W sampling edges leaves the filtered output unchanged.
- R9: With spike_i = 0 the filter adds no delay beyond synchronisation, so a one-edge pulse shows at edge k + 2.
- R10: With the block idle, `run_i` = 1 at an edge drives `scl_o` low from the next cycle. With `run_i` = 0 when a high phase ends, `scl_o` stays 1 and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Keep generating clock periods |
| mult_i | input | MUL_W | Prescale multiplier, scale = value + 1 |
| spike_i | input | SPK_W | Glitch width in prescaled units |
| high_i | input | HI_W | SCL high count |
| ratio2_i | input | 1 | 1: low count uses twice the high count |
| setup_i | input | SU_W | Data setup count |
| hold_i | input | HD_W | Data hold count |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_o | output | 1 | SCL drive level, 1 = released |
| scl_filt_o | output | 1 | Filtered SCL level |
| sda_filt_o | output | 1 | Filtered SDA level |
| sda_chg_o | output | 1 | Strobe: SDA may change now |
| scl_rel_o | output | 1 | Strobe: last low cycle, SCL released next |

## Verification
Phase lengths have no fixed latency from a single stimulus. A driver therefore queues the expected low length, hold index and high length for every period. A monitor samples on the falling clock edge and settles each low item in the first high cycle and each high item in the first low cycle. The high count starts from the first cycle in which `scl_filt_o` is seen at 1, so the check holds whether or not the clock is stretched. Filter results are due at edge k + 2 + W after the first sampling edge k. The bench walks the cycles one by one and records the exact index of the first change, or records that no change came. The start of a run is due one cycle after `run_i` is sampled.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam int unsigned NUM_SPANS  = 4;
  localparam int unsigned SPAN_HIGH  = 0;
  localparam int unsigned SPAN_LOW   = 1;
  localparam int unsigned SPAN_SETUP = 2;
  localparam int unsigned SPAN_HOLD  = 3;
endpackage

// File: rtl/scl_span_calc.sv
module scl_span_calc #(
  parameter int unsigned MUL_W = 5,
  parameter int unsigned SPK_W = 3,
  parameter int unsigned X_W   = 10,
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MUL_W-1:0] mult_i,
  input  logic [SPK_W-1:0] spike_i,
  input  logic [X_W-1:0]   x_i,
  output logic [CNT_W-1:0] span_o
);
  localparam int unsigned SUM_W = X_W + 2;

  logic [SUM_W-1:0] sum_d;
  logic [MUL_W:0]   scale_d;
  logic [CNT_W-1:0] span_d;

  // span = 2 + (2 + spike + x) * (mult + 1)
  assign sum_d   = SUM_W'(2) + SUM_W'(spike_i) + SUM_W'(x_i);
  assign scale_d = (MUL_W+1)'(mult_i) + (MUL_W+1)'(1);
  assign span_d  = CNT_W'(sum_d) * CNT_W'(scale_d) + CNT_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) span_o <= CNT_W'(4);
    else         span_o <= span_d;
  end
endmodule

// File: rtl/scl_spike_filter.sv
module scl_spike_filter #(
  parameter int unsigned W_W = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           d_i,
  input  logic [W_W-1:0] width_i,
  output logic           q_o
);
  logic [1:0]     sync_q;
  logic [W_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      q_o    <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], d_i};
      if (sync_q[1] == q_o) begin
        cnt_q <= '0;
      end else if (cnt_q >= width_i) begin
        // differing level outlasted the glitch width
        q_o   <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + W_W'(1);
      end
    end
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_tgen_pkg::*;
#(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             scl_seen_i,
  input  logic [CNT_W-1:0] hi_span_i,
  input  logic [CNT_W-1:0] lo_span_i,
  input  logic [CNT_W-1:0] su_span_i,
  input  logic [CNT_W-1:0] hd_span_i,
  output logic             scl_o,
  output logic             sda_chg_o,
  output logic             scl_rel_o
);
  localparam int unsigned E_W = CNT_W + 1;

  phase_e         ph_q, ph_d;
  logic [E_W-1:0] el_q, el_d;
  logic [E_W-1:0] pair_len, lo_len, hi_len, hd_len;
  logic           scl_q;
  logic           lo_end, hi_go, hi_end;

  // low phase must cover hold plus setup as well as its own span
  assign pair_len = E_W'(hd_span_i) + E_W'(su_span_i);
  assign lo_len   = (pair_len > E_W'(lo_span_i)) ? pair_len : E_W'(lo_span_i);
  assign hi_len   = E_W'(hi_span_i);
  assign hd_len   = E_W'(hd_span_i);

  assign lo_end = (ph_q == PH_LOW) && (el_q == lo_len - E_W'(1));
  // high count waits for the line to be seen high (clock stretch)
  assign hi_go  = (ph_q == PH_HIGH) && ((el_q != '0) || scl_seen_i);
  assign hi_end = hi_go && (el_q == hi_len - E_W'(1));

  always_comb begin
    ph_d = ph_q;
    el_d = el_q;
    case (ph_q)
      PH_IDLE: begin
        if (run_i) begin
          ph_d = PH_LOW;
          el_d = '0;
        end
      end
      PH_LOW: begin
        if (lo_end) begin
          ph_d = PH_HIGH;
          el_d = '0;
        end else begin
          el_d = el_q + E_W'(1);
        end
      end
      PH_HIGH: begin
        if (hi_end) begin
          ph_d = run_i ? PH_LOW : PH_IDLE;
          el_d = '0;
        end else if (hi_go) begin
          el_d = el_q + E_W'(1);
        end
      end
      default: begin
        ph_d = PH_IDLE;
        el_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      el_q  <= '0;
      scl_q <= 1'b1;
    end else begin
      ph_q  <= ph_d;
      el_q  <= el_d;
      scl_q <= (ph_d != PH_LOW);
    end
  end

  assign scl_o     = scl_q;
  assign sda_chg_o = (ph_q == PH_LOW) && (el_q == hd_len);
  assign scl_rel_o = lo_end;
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tgen_pkg::*;
#(
  parameter int unsigned MUL_W = 5,
  parameter int unsigned SPK_W = 3,
  parameter int unsigned HI_W  = 9,
  parameter int unsigned SU_W  = 5,
  parameter int unsigned HD_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [MUL_W-1:0] mult_i,
  input  logic [SPK_W-1:0] spike_i,
  input  logic [HI_W-1:0]  high_i,
  input  logic             ratio2_i,
  input  logic [SU_W-1:0]  setup_i,
  input  logic [HD_W-1:0]  hold_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_o,
  output logic             scl_filt_o,
  output logic             sda_filt_o,
  output logic             sda_chg_o,
  output logic             scl_rel_o
);
  localparam int unsigned X_W   = HI_W + 1;
  localparam int unsigned CNT_W = X_W + MUL_W + 3;
  localparam int unsigned FW_W  = SPK_W + MUL_W + 1;

  logic [X_W-1:0]   span_x [NUM_SPANS];
  logic [CNT_W-1:0] span_q [NUM_SPANS];
  logic [FW_W-1:0]  flt_w_d, flt_w_q;
  logic [1:0]       line_raw, line_flt;

  always_comb begin
    span_x[SPAN_HIGH]  = X_W'(high_i);
    span_x[SPAN_LOW]   = ratio2_i ? {high_i, 1'b0} : X_W'(high_i);
    span_x[SPAN_SETUP] = X_W'(setup_i);
    span_x[SPAN_HOLD]  = X_W'(hold_i);
  end

  for (genvar g = 0; g < NUM_SPANS; g++) begin : g_span
    scl_span_calc #(
      .MUL_W(MUL_W),
      .SPK_W(SPK_W),
      .X_W  (X_W),
      .CNT_W(CNT_W)
    ) u_span (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mult_i (mult_i),
      .spike_i(spike_i),
      .x_i    (span_x[g]),
      .span_o (span_q[g])
    );
  end

  assign flt_w_d = FW_W'(spike_i) * (FW_W'(mult_i) + FW_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flt_w_q <= '0;
    else         flt_w_q <= flt_w_d;
  end

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    scl_spike_filter #(
      .W_W(FW_W)
    ) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (line_raw[g]),
      .width_i(flt_w_q),
      .q_o    (line_flt[g])
    );
  end

  assign scl_filt_o = line_flt[0];
  assign sda_filt_o = line_flt[1];

  scl_phase_fsm #(
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .scl_seen_i(line_flt[0]),
    .hi_span_i (span_q[SPAN_HIGH]),
    .lo_span_i (span_q[SPAN_LOW]),
    .su_span_i (span_q[SPAN_SETUP]),
    .hd_span_i (span_q[SPAN_HOLD]),
    .scl_o     (scl_o),
    .sda_chg_o (sda_chg_o),
    .scl_rel_o (scl_rel_o)
  );
endmodule

// File: rtl/scl_tgen_chk.sv
module scl_tgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic scl_o,
  input logic scl_filt_o,
  input logic sda_filt_o,
  input logic sda_chg_o,
  input logic scl_rel_o
);
  // R6
  rel_then_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rel_o |=> scl_o);

  // R6
  rel_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rel_o |-> !scl_o);

  // R6
  rise_after_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_o) |-> $past(scl_rel_o));

  // R5
  chg_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_chg_o |-> (!scl_o && !scl_rel_o));

  // R5
  chg_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_chg_o |=> !sda_chg_o);

  // R7
  scl_filt_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_filt_o) |-> (scl_filt_o == $past(scl_i, 3)));

  // R7
  sda_filt_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_filt_o) |-> (sda_filt_o == $past(sda_i, 3)));
endmodule

bind scl_timing_gen scl_tgen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_i     (sda_i),
  .scl_o     (scl_o),
  .scl_filt_o(scl_filt_o),
  .sda_filt_o(sda_filt_o),
  .sda_chg_o (sda_chg_o),
  .scl_rel_o (scl_rel_o)
);

// File: tb/scl_timing_gen_tb.sv
`timescale 1ns/1ps
module scl_timing_gen_tb;
  localparam int MUL_W = 5;
  localparam int SPK_W = 3;
  localparam int HI_W  = 9;
  localparam int SU_W  = 5;
  localparam int HD_W  = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic [MUL_W-1:0] mult = '0;
  logic [SPK_W-1:0] spike = '0;
  logic [HI_W-1:0]  high = 9'd4;
  logic             ratio2 = 1'b0;
  logic [SU_W-1:0]  setup = '0;
  logic [HD_W-1:0]  hold = '0;
  logic             stretch = 1'b0;
  logic             sda_in = 1'b1;
  logic             scl_line;
  logic             scl_o, scl_filt_o, sda_filt_o, sda_chg_o, scl_rel_o;

  int n_cmp = 0;
  int n_mis = 0;
  int lo_q[$];
  int hd_q[$];
  int hi_q[$];

  always #10 clk = ~clk;

  // slave model: open-drain line pulled low while stretching
  assign scl_line = scl_o & ~stretch;

  scl_timing_gen #(
    .MUL_W(MUL_W), .SPK_W(SPK_W), .HI_W(HI_W), .SU_W(SU_W), .HD_W(HD_W)
  ) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .run_i     (run),
    .mult_i    (mult),
    .spike_i   (spike),
    .high_i    (high),
    .ratio2_i  (ratio2),
    .setup_i   (setup),
    .hold_i    (hold),
    .scl_i     (scl_line),
    .sda_i     (sda_in),
    .scl_o     (scl_o),
    .scl_filt_o(scl_filt_o),
    .sda_filt_o(sda_filt_o),
    .sda_chg_o (sda_chg_o),
    .scl_rel_o (scl_rel_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_mis++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int span(input int m, input int sp, input int x);
    return 2 + (2 + sp + x) * (m + 1);
  endfunction

  // monitor: settles queued expectations at phase boundaries
  logic prev_scl = 1'b1;
  logic hi_arm = 1'b0;
  logic hi_on = 1'b0;
  logic rel_last = 1'b0;
  int   low_cnt = 0;
  int   chg_idx = -1;
  int   chg_n = 0;
  int   hi_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!scl_o) begin
        if (prev_scl) begin
          if (hi_on) begin
            if (hi_q.size() > 0) chk("R3 high length", hi_cnt, hi_q.pop_front());
            else                 chk("R3 unexpected high", hi_cnt, -1);
          end
          hi_on = 1'b0; hi_arm = 1'b0;
          low_cnt = 0; chg_n = 0; chg_idx = -1; rel_last = 1'b0;
        end
        if (sda_chg_o) begin
          chg_idx = low_cnt;
          chg_n++;
        end
        rel_last = scl_rel_o;
        low_cnt++;
      end else begin
        if (!prev_scl) begin
          if (lo_q.size() > 0) begin
            chk("R2 low length", low_cnt, lo_q[0]);
            chk("R5 hold index", chg_idx, hd_q[0]);
            chk("R5 strobe count", chg_n, 1);
            chk("R6 release strobe", rel_last, 1);
            void'(lo_q.pop_front());
            void'(hd_q.pop_front());
          end else begin
            chk("R2 unexpected low", low_cnt, -1);
          end
          hi_arm = 1'b1;
          hi_cnt = 0;
        end
        if (hi_arm && scl_filt_o) hi_on = 1'b1;
        if (hi_on) hi_cnt++;
        if (!run) begin
          hi_on = 1'b0;
          hi_arm = 1'b0;
        end
      end
      prev_scl = scl_o;
    end
  end

  task automatic filt_pulse(input int m, input int sp, input int len);
    int w;
    int first;
    int exp_first;
    string tag;
    mult = MUL_W'(m);
    spike = SPK_W'(sp);
    repeat (4) @(negedge clk);
    w = sp * (m + 1);
    exp_first = (len >= w + 1) ? 3 + w : -1;
    tag = (sp == 0) ? "R9 zero-spike latency" : ((len >= w + 1) ? "R7 filter latency" : "R8 pulse suppressed");
    first = -1;
    sda_in = 1'b0;
    for (int k = 1; k <= len + w + 12; k++) begin
      @(negedge clk);
      if (k == len) sda_in = 1'b1;
      if (!sda_filt_o && first < 0) first = k;
    end
    chk(tag, first, exp_first);
    chk("R7 filter settles high", sda_filt_o, 1);
  endtask

  task automatic run_periods(input int m, input int sp, input int hi, input int r,
                             input int su, input int hd, input int n, input int stretch_n);
    int th, tl, tsu, thd, ll;
    bit ok;
    mult = MUL_W'(m); spike = SPK_W'(sp); high = HI_W'(hi);
    ratio2 = r[0]; setup = SU_W'(su); hold = HD_W'(hd);
    repeat (3) @(negedge clk);
    th  = span(m, sp, hi);
    tl  = span(m, sp, hi * (r != 0 ? 2 : 1));
    tsu = span(m, sp, su);
    thd = span(m, sp, hd);
    ll  = (tl > thd + tsu) ? tl : thd + tsu;
    for (int i = 0; i < n; i++) begin
      lo_q.push_back(ll);
      hd_q.push_back(thd);
    end
    for (int i = 0; i < n - 1; i++) hi_q.push_back(th);
    stretch = (stretch_n > 0);
    run = 1'b1;
    @(negedge clk);
    chk("R10 start low", scl_o, 0);
    if (stretch_n > 0) begin
      while (lo_q.size() == n) @(negedge clk);
      ok = 1'b1;
      repeat (stretch_n) begin
        @(negedge clk);
        if (!scl_o) ok = 1'b0;
      end
      chk("R4 held high while stretched", ok, 1);
      stretch = 1'b0;
    end
    while (lo_q.size() != 0) @(negedge clk);
    run = 1'b0;
    ok = 1'b1;
    repeat (th + 40) begin
      @(negedge clk);
      if (!scl_o || sda_chg_o || scl_rel_o) ok = 1'b0;
    end
    chk("R10 stays high after stop", ok, 1);
    chk("R3 high items left", hi_q.size(), 0);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk("R1 scl_o in reset", scl_o, 1);
    chk("R1 scl_filt in reset", scl_filt_o, 1);
    chk("R1 sda_filt in reset", sda_filt_o, 1);
    chk("R1 strobes in reset", sda_chg_o | scl_rel_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", scl_o, 1);
    filt_pulse(1, 2, 4);
    filt_pulse(1, 2, 5);
    filt_pulse(0, 3, 3);
    filt_pulse(0, 3, 4);
    filt_pulse(0, 0, 1);
    run_periods(0, 0, 4, 0, 1, 1, 3, 0);
    run_periods(1, 1, 5, 1, 2, 2, 3, 0);
    run_periods(2, 2, 9, 0, 3, 4, 2, 0);
    run_periods(0, 0, 4, 0, 1, 1, 3, 25);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      n_cmp++;
      n_mis++;
      $display("FAIL R10 watchdog: actual hung expected finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule